// File: doc/BRIEF.md
# Duplicated-Pipeline Stage Completion Controller

This block is the completion and handshake controller for one stage of a duplicated sleep-convention pipeline. One instance serves one copy. It watches the dual-rail signals that feed the stage's registers in its own copy. It reports complete DATA once every bit carries a valid code. From that result and the requests of the following stage it drives the acknowledge output `ko`. A high `ko` asks for DATA and a low `ko` asks for NULL.

Hardening against a single-copy fault comes from two agreement points. First, the requests from the next stage of both copies meet in a two-input hysteresis gate. A lone corrupted request therefore cannot move the merged request. Second, the detection logic is put to sleep (forced to NULL) only when the sleep signals from both copies are high. The asynchronous behaviour is modelled with a sampling clock, so each gate with hysteresis, and the completion flag, is one register stage.

Top module: `ecd_stage`

## Requirements
- R1: While reset is applied and on the first cycle after it, `ko` is 1 (request for data), and the completion state is clear.
- R2: When both `ki_a` and `ki_b` are 1 and the last NULL bit of the data input turns to DATA, `ko` falls to 0 exactly two clock edges after the input change. A bit is DATA when exactly one of its rails (`d_r0[i]`, `d_r1[i]`) is 1. It is NULL when both rails are 0.
- R3: While any data bit is NULL, `ko` does not fall.
- R4: Once `slp_a` and `slp_b` are both 1 and `ki_a` and `ki_b` are both 0, `ko` returns to 1 exactly two clock edges later.
- R5: While `ki_a` and `ki_b` differ, `ko` keeps its value. A single-copy glitch on one request has no effect.
- R6: With only one of `slp_a`/`slp_b` high, the detected DATA is kept, and `ko` stays 0 even when both requests are low.
- R7: `ko` never falls while the merged request is low. With both requests at 0, complete DATA leaves `ko` at 1.
- R8: After DATA has been detected, a data bit returning to NULL without a two-copy sleep does not raise `ko`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| d_r0 | input | N | Rail 0 of each dual-rail register input |
| d_r1 | input | N | Rail 1 of each dual-rail register input |
| slp_a | input | 1 | Sleep from the previous stage, own copy |
| slp_b | input | 1 | Sleep from the previous stage, other copy |
| ki_a | input | 1 | Request from the next stage, copy A |
| ki_b | input | 1 | Request from the next stage, copy B |
| ko | output | 1 | Acknowledge: 1 request for data, 0 request for null |

## Verification
A change on the data inputs reaches `ko` after two edges: one into the completion flag, one into the output hysteresis gate. A change on the requests also takes two edges: one into the merge gate, one into the output gate. A two-copy sleep clears the flag on the first edge, and `ko` rises on the second. The bench drives inputs just after an edge and samples one time unit after the edge where a result is due. It probes the cycle before as well, so that an early or late change is caught. In the randomized four-phase rounds, glitches on one request or one sleep line are injected. Each phase then allows a bounded number of cycles for `ko` to reach the value of a fault-free run, and a timeout counts as a deadlock.

// File: rtl/ecd_pkg.sv
`timescale 1ns/1ps
package ecd_pkg;

    typedef enum logic {
        REQ_NULL = 1'b0,
        REQ_DATA = 1'b1
    } req_e;

    // A dual-rail bit carries a valid code when either rail is raised
    function automatic logic rail_valid(input logic r0, input logic r1);
        return r0 | r1;
    endfunction

    // Detection gates only sleep when both copies agree
    function automatic logic joint_sleep(input logic sa, input logic sb);
        return sa & sb;
    endfunction

    // Number of tree levels for a given width (at least one)
    function automatic int tree_levels(input int width);
        return (width > 1) ? $clog2(width) : 1;
    endfunction

endpackage

// File: rtl/ecd_rail_level.sv
`timescale 1ns/1ps
module ecd_rail_level
    import ecd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] r0,
    input  logic [N-1:0] r1,
    input  logic         slp_a,
    input  logic         slp_b,
    output logic [N-1:0] bit_ok
);
    logic asleep;
    assign asleep = joint_sleep(slp_a, slp_b);

    // First-level gate per dual-rail bit, held at NULL while slept
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign bit_ok[i] = ~asleep & rail_valid(r0[i], r1[i]);
    end
endmodule

// File: rtl/ecd_all_tree.sv
`timescale 1ns/1ps
module ecd_all_tree
    import ecd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] leaves,
    output logic         all_set
);
    localparam int LVL = tree_levels(N);
    localparam int P   = 1 << LVL;

    // Heap-ordered node array: node[1] is the root, leaves at P..2P-1
    logic node [1:2*P-1];

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign node[P+i] = leaves[i];
        end else begin : g_pad
            assign node[P+i] = 1'b1;
        end
    end

    for (genvar k = 1; k < P; k++) begin : g_node
        assign node[k] = node[2*k] & node[2*k+1];
    end

    assign all_set = node[1];
endmodule

// File: rtl/ecd_hyst2.sv
`timescale 1ns/1ps
module ecd_hyst2 #(
    parameter bit INIT   = 1'b0,
    parameter bit INVERT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic a,
    input  logic b,
    output logic y
);
    logic st;

    // Two-input gate with hysteresis: set on both high, clear on both low
    always_ff @(posedge clk) begin
        if (rst)
            st <= INIT;
        else if (a && b)
            st <= 1'b1;
        else if (!a && !b)
            st <= 1'b0;
    end

    assign y = INVERT ? ~st : st;

    AST_HYST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (a != b) |=> (st == $past(st)));                       // R5

    AST_HYST_SET: assert property (@(posedge clk) disable iff (rst)
        (a && b) |=> st);                                      // R2
endmodule

// File: rtl/ecd_stage.sv
`timescale 1ns/1ps
module ecd_stage
    import ecd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_r0,
    input  logic [N-1:0] d_r1,
    input  logic         slp_a,
    input  logic         slp_b,
    input  logic         ki_a,
    input  logic         ki_b,
    output logic         ko
);
    logic [N-1:0] bit_ok;
    logic         all_data;
    logic         det_q;
    logic         req_merged;
    logic         asleep;

    assign asleep = joint_sleep(slp_a, slp_b);

    ecd_rail_level #(.N(N)) u_level (
        .r0     (d_r0),
        .r1     (d_r1),
        .slp_a  (slp_a),
        .slp_b  (slp_b),
        .bit_ok (bit_ok)
    );

    ecd_all_tree #(.N(N)) u_tree (
        .leaves  (bit_ok),
        .all_set (all_data)
    );

    // Completion flag: raised by complete DATA, cleared only by a joint sleep
    always_ff @(posedge clk) begin
        if (rst)
            det_q <= 1'b0;
        else if (asleep)
            det_q <= 1'b0;
        else if (all_data)
            det_q <= 1'b1;
    end

    // Merge of next-stage requests from both copies
    ecd_hyst2 #(.INIT(1'b0), .INVERT(1'b0)) u_merge (
        .clk (clk),
        .rst (rst),
        .a   (ki_a),
        .b   (ki_b),
        .y   (req_merged)
    );

    // Final inverting hysteresis gate producing the acknowledge
    ecd_hyst2 #(.INIT(1'b0), .INVERT(1'b1)) u_final (
        .clk (clk),
        .rst (rst),
        .a   (req_merged),
        .b   (det_q),
        .y   (ko)
    );

    AST_KO_RESET: assert property (@(posedge clk)
        rst |=> (ko == REQ_DATA));                              // R1

    AST_DET_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(det_q) |-> $past(&(d_r0 | d_r1)));                // R3

    AST_SINGLE_SLEEP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (det_q && !(slp_a && slp_b)) |=> det_q);                // R6

    AST_KO_FALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $fell(ko) |-> $past(req_merged));                       // R7

    AST_JOINT_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (slp_a && slp_b) |=> !det_q);                           // R4
endmodule

// File: tb/sim_ecd_stage.sv
`timescale 1ns/1ps
module sim_ecd_stage;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] d_r0, d_r1;
    logic         slp_a, slp_b, ki_a, ki_b;
    logic         ko;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ecd_stage #(.N(N)) u0 (
        .clk(clk), .rst(rst), .d_r0(d_r0), .d_r1(d_r1),
        .slp_a(slp_a), .slp_b(slp_b), .ki_a(ki_a), .ki_b(ki_b), .ko(ko)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (ko !== exp) begin
            fails++;
            $display("FAIL %s: ko=%b expected=%b at %0t", req, ko, exp, $time);
        end
    endtask

    // Wait a bounded time for ko to reach exp; timeout means deadlock
    task automatic settle(input string req, input logic exp);
        for (int i = 0; i < 20 && ko !== exp; i++) tick(1);
        check(req, exp);
    endtask

    function automatic logic [2*N-1:0] rand_data(input int unsigned v);
        logic [N-1:0] r1v = v[N-1:0];
        return {r1v, ~r1v};
    endfunction

    initial begin
        #150000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] dv;
        void'($urandom(32'd1234));
        rst = 1; d_r0 = '0; d_r1 = '0;
        slp_a = 0; slp_b = 0; ki_a = 1; ki_b = 1;
        tick(3);
        check("R1", 1'b1);
        rst = 0;
        tick(1);
        check("R1", 1'b1);

        // Partial DATA: bit 0 still NULL
        d_r1 = 8'hA4; d_r0 = 8'h5A;
        tick(4);
        check("R3", 1'b1);

        // Complete DATA with both requests high
        d_r1[0] = 1'b1;
        tick(1);
        check("R2", 1'b1);
        tick(1);
        check("R2", 1'b0);

        // A bit falls back to NULL without sleep
        d_r0[3] = 1'b0; d_r1[3] = 1'b0;
        tick(3);
        check("R8", 1'b0);

        // One request drops, then both
        ki_a = 0;
        tick(3);
        check("R5", 1'b0);
        ki_b = 0;
        tick(3);
        check("R6", 1'b0);

        // Only one sleep high
        slp_a = 1;
        tick(3);
        check("R6", 1'b0);

        // Joint sleep returns ko high after two edges
        slp_b = 1;
        tick(1);
        check("R4", 1'b0);
        tick(1);
        check("R4", 1'b1);

        // Complete DATA but merged request low
        slp_a = 0; slp_b = 0;
        d_r1 = 8'h0F; d_r0 = 8'hF0;
        tick(4);
        check("R7", 1'b1);
        ki_b = 1;
        tick(3);
        check("R5", 1'b1);
        ki_a = 1;
        tick(1);
        check("R2", 1'b1);
        tick(1);
        check("R2", 1'b0);

        // Return to NULL
        d_r0 = '0; d_r1 = '0;
        ki_a = 0; ki_b = 0; slp_a = 1; slp_b = 1;
        tick(2);
        check("R4", 1'b1);

        // Randomized four-phase rounds with single-copy glitches
        for (int r = 0; r < 40; r++) begin
            int unsigned g = $urandom % 4;
            dv = rand_data($urandom);
            slp_a = 0; slp_b = 0;
            ki_a = 1; ki_b = 1;
            d_r1 = dv[2*N-1:N]; d_r0 = dv[N-1:0];
            if (g == 0) begin ki_a = 0; tick(1 + $urandom % 3); ki_a = 1; end
            if (g == 1) begin slp_b = 1; tick(1 + $urandom % 3); slp_b = 0; end
            settle("R2", 1'b0);
            if (g == 2) begin ki_b = 0; tick(2); check("R5", 1'b0); ki_b = 1; end
            d_r0 = '0; d_r1 = '0;
            ki_a = 0; ki_b = 0;
            if (g == 3) begin slp_a = 1; tick(2); check("R6", 1'b0); end
            if (g == 1) begin ki_a = 1; tick(2); check("R5", 1'b0); ki_a = 0; end
            slp_a = 1; slp_b = 1;
            settle("R4", 1'b1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule